// File: doc/BRIEF.md
# Dual-Threshold Level Detector for AGC

This block watches a stream of signed IF samples from an external A/D converter and turns it into a one-bit gain error for an analog AGC loop. It takes the absolute value of each accepted sample and keeps the largest value seen over a window of 2^K accepted samples. At the close of each window it compares that peak with two programmable limits.

A peak above the upper limit drives the error bit low, which asks for less gain. A peak below the lower limit drives it high, which asks for more gain. A peak at or between the limits leaves the bit unchanged, so the two limits form a hysteresis band. Because the bit updates only once per window, a lone noisy sample cannot toggle it from one sample to the next. The loop filter and the gain stage that act on the bit sit outside this block.

Top module: `agc_level_det`

## Requirements
- R1: The magnitude of each sample is its absolute value, with samples in two's complement (for example -5 gives 5 and 7 gives 7).
- R2: The most negative code (-32 at the default 6-bit width) saturates to the largest positive magnitude, 31.
- R3: A window is 2^K accepted samples, where K is `win_log2` clamped to at most MAXK (default 8). The value compared is the largest magnitude within that window.
- R4: `agc_err` changes only on the clock edge that accepts the last sample of a window. At all other times it holds its value.
- R5: At a window end, if the peak is strictly greater than `thr_hi`, `agc_err` becomes 0.
- R6: At a window end, if the peak is not above `thr_hi` and is strictly less than `thr_lo`, `agc_err` becomes 1.
- R7: At a window end, if the peak is within `thr_lo`..`thr_hi` inclusive, `agc_err` keeps its previous value.
- R8: When `thr_lo` is greater than `thr_hi` and the peak satisfies both comparisons, the upper comparison wins and `agc_err` becomes 0.
- R9: Reset (`rst_n` low) forces `agc_err` to 1, clears the peak and restarts the window count.
- R10: A sample presented with `smp_valid` low does not count toward the window and does not affect the peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | 6 | Signed A/D sample |
| thr_hi | input | 5 | Upper magnitude limit |
| thr_lo | input | 5 | Lower magnitude limit |
| win_log2 | input | 4 | Window size exponent K, clamped to MAXK |
| agc_err | output | 1 | Gain error: 0 means reduce gain, 1 means increase gain |

## Verification
A wrong sample count or peak register shows at the port only when a window closes. The error bit then moves at the wrong edge, or takes the wrong level for a given set of samples. A fault is therefore visible at most one window, 2^K accepted samples, after it occurs. The bench models the window count and the peak from the requirements and compares the error bit on every cycle. Because the fault appears at the end of the window itself, short windows expose counting faults within a few cycles. Directed cases probe the saturated code, the thresholds at equality, crossed limits and the clamp on K.

// File: rtl/agc_level_det.sv
module agc_level_det #(
  parameter int DW   = 6,
  parameter int MAXK = 8,
  parameter int KW   = $clog2(MAXK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic [DW-2:0] thr_hi,
  input  logic [DW-2:0] thr_lo,
  input  logic [KW-1:0] win_log2,
  output logic          agc_err
);
  localparam int MW = DW - 1;
  localparam logic [MW-1:0] MAXMAG = {MW{1'b1}};

  logic [MW-1:0]   low, nlow, mag, pk, pk_nx;
  logic [KW-1:0]   klim;
  logic [MAXK-1:0] mask, cnt;
  logic            neg, win_end;

  assign neg   = smp_data[DW-1];
  assign low   = smp_data[MW-1:0];
  assign nlow  = ~low + 1'b1;
  assign mag   = !neg ? low : (low == '0) ? MAXMAG : nlow;

  assign klim    = (win_log2 > KW'(MAXK)) ? KW'(MAXK) : win_log2;
  assign mask    = ~({MAXK{1'b1}} << klim);
  assign win_end = smp_valid && (cnt == mask);
  assign pk_nx   = (mag > pk) ? mag : pk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pk      <= '0;
      agc_err <= 1'b1;
    end else if (win_end) begin
      cnt <= '0;
      pk  <= '0;
      if (pk_nx > thr_hi)
        agc_err <= 1'b0;
      else if (pk_nx < thr_lo)
        agc_err <= 1'b1;
    end else if (smp_valid) begin
      cnt <= cnt + 1'b1;
      pk  <= pk_nx;
    end
  end
endmodule

module agc_level_det_chk #(
  parameter int DW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic [DW-1:0] smp_data,
  input logic          win_end,
  input logic [DW-2:0] mag,
  input logic [DW-2:0] pk,
  input logic [DW-2:0] pk_nx,
  input logic [DW-2:0] thr_hi,
  input logic [DW-2:0] thr_lo,
  input logic          agc_err
);
  localparam logic [DW-1:0] MOSTNEG = {1'b1, {(DW-1){1'b0}}};

  assert_mag_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_data == MOSTNEG) |-> (mag == {(DW-1){1'b1}}));
  assert_peak_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !win_end) |=> (pk >= $past(mag)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(agc_err));
  assert_strong_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && pk_nx > thr_hi) |=> !agc_err);
  assert_weak_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && pk_nx <= thr_hi && pk_nx < thr_lo) |=> agc_err);
  assert_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && pk_nx <= thr_hi && pk_nx >= thr_lo) |=> $stable(agc_err));
  assert_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && thr_lo > thr_hi && pk_nx > thr_hi) |=> !agc_err);
  assert_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> agc_err);
endmodule

bind agc_level_det agc_level_det_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
  .win_end(win_end), .mag(mag), .pk(pk), .pk_nx(pk_nx),
  .thr_hi(thr_hi), .thr_lo(thr_lo), .agc_err(agc_err)
);

// File: tb/test_agc_level_det.sv
`timescale 1ns/1ps
module test_agc_level_det;
  logic clk = 0, rst_n = 0, smp_valid = 0, agc_err;
  logic [5:0] smp_data = '0;
  logic [4:0] thr_hi = '0, thr_lo = '0;
  logic [3:0] win_log2 = '0;
  int checks = 0, errors = 0;
  int m_cnt = 0, m_pk = 0;
  bit m_err = 1, done = 0;

  always #4 clk = ~clk;

  agc_level_det i_agc_level_det (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .win_log2(win_log2), .agc_err(agc_err));

  function automatic int magof(logic [5:0] d);
    int v = $signed(d);
    if (v == -32) return 31;
    return v < 0 ? -v : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; smp_valid = 0;
    m_cnt = 0; m_pk = 0; m_err = 1;
    @(posedge clk); #2;
    chk("R9 reset level", agc_err, 1);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic step(bit v, logic [5:0] d, int hi, int lo, int k, string tag);
    int kk, len, mg;
    @(negedge clk);
    smp_valid = v; smp_data = d; thr_hi = 5'(hi); thr_lo = 5'(lo); win_log2 = 4'(k);
    kk = k > 8 ? 8 : k; len = 1 << kk;
    if (v) begin
      mg = magof(d);
      if (mg > m_pk) m_pk = mg;
      if (m_cnt == len - 1) begin
        if (m_pk > hi) m_err = 0;
        else if (m_pk < lo) m_err = 1;
        m_cnt = 0; m_pk = 0;
      end else m_cnt++;
    end
    @(posedge clk); #2;
    chk(tag, agc_err, m_err);
  endtask

  initial begin
    void'($urandom(32'd4021));
    do_reset();
    // R1: K=0, -5 vs hi=4 gives 0; then 3 vs lo=4 gives 1
    step(1, -6'sd5, 4, 1, 0, "R1 abs of -5");
    chk("R1 strong", agc_err, 0);
    step(1, 6'sd3, 10, 4, 0, "R1 abs of 3");
    chk("R6 weak", agc_err, 1);
    // R2: -32 saturates to 31
    step(1, 6'b100000, 30, 0, 0, "R2 sat above 30");
    chk("R2 sat 31>30", agc_err, 0);
    do_reset();
    step(1, 6'b100000, 31, 0, 0, "R2 sat equals 31");
    chk("R7 hold at equality", agc_err, 1);
    // R8: crossed limits, peak above both
    step(1, 6'sd20, 10, 25, 0, "R8 crossed");
    chk("R8 upper wins", agc_err, 0);
    step(1, 6'sd15, 20, 10, 0, "R7 between");
    chk("R7 between holds", agc_err, 0);
    // R10: invalid big samples ignored, K=1
    do_reset();
    step(1, 6'sd2, 10, 1, 1, "R10 v1");
    for (int i = 0; i < 5; i++) step(0, 6'b100000, 10, 1, 1, "R10 invalid");
    step(1, 6'sd2, 10, 1, 1, "R10 v2");
    chk("R10 no effect of invalid", agc_err, 1);
    // R3 clamp: K=12 acts as 256
    do_reset();
    for (int i = 0; i < 255; i++) step(1, 6'sd20, 10, 1, 12, "R3 clamp");
    chk("R3 before window end", agc_err, 1);
    step(1, 6'sd0, 10, 1, 12, "R3 last");
    chk("R3 after 256 samples", agc_err, 0);
    // random phases; per-cycle compare covers R4 R5 R6 R7
    for (int ph = 0; ph < 6; ph++) begin
      int k = (ph == 5) ? 8 : ph;
      int hi = $urandom_range(31), lo = $urandom_range(31);
      do_reset();
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(99) < 3) begin
          hi = $urandom_range(31); lo = $urandom_range(31);
        end
        step($urandom_range(3) != 0, 6'($urandom), hi, lo, k, "R4 random");
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule